// File: doc/BRIEF.md
# Bus-Cycle Stepping Monitor

This block generates the phase-2 clock for a 6502-style processor and decides, under command, whether that clock runs freely, holds, advances by one bus cycle, or advances until the next instruction boundary. It also drives the processor's active-low reset line. A debug host issues one-cycle commands. The block follows the processor's address, data, read/write and opcode-sync lines.

Each bus cycle ends when PHI2 falls. At that edge the block samples the bus, classifies the cycle as a read, a write or an opcode fetch, and tags it with the number of cycles completed since the processor reset was released. The result goes out as one record on a valid/ready stream. If the consumer is not ready, PHI2 stays high, so the cycle is stretched and no record is lost.

Bus timing follows the falling edge of PHI2. The processor changes its address and read/write lines after the fall, so the low phase has a programmable minimum length. This gives those lines time to settle before the next rise. The high phase lasts a fixed number of system clocks set by a parameter.

Top module: `busstep_monitor`

## Requirements
- R1: While `rst_n` is low and after it is released, `phi2` is 0, `resb` is 0, `trace_valid` is 0, and the clock holds with `phi2` low until a command arrives.
- R2: Each low phase of `phi2` lasts at least `cfg_low_len`+1 system clocks, and exactly that long when the clock is running and the trace slot is free. Each high phase lasts at least `HIGH_LEN` clocks, and exactly `HIGH_LEN` when the trace slot is free.
- R3: Command code 1 (run) lets cycles follow one another without a stop. Code 0 (hold) stops the clock with `phi2` low before the next rise.
- R4: Code 2 (cycle step) completes exactly one bus cycle, then holds with `phi2` low.
- R5: Code 3 (instruction step) runs at least one cycle. It then holds just before the rise of the first later cycle whose `cpu_sync` is high at the end of the low phase. Every record after the first one in the step is a non-fetch.
- R6: Code 4 drives `resb` low on the next clock, and code 5 drives it high. Neither code changes the run mode.
- R7: `trace_count` is the number of cycles completed since `resb` last went high, counting the present cycle. The first cycle after release reports 1. A cycle that ends while `resb` is low reports 0.
- R8: The cycle count saturates at its all-ones value (`2**CNT_W-1`) and does not wrap.
- R9: `trace_kind` is 1 (write) when `cpu_rw` is low, 2 (opcode fetch) when `cpu_sync` and `cpu_rw` are both high, and 0 (read) otherwise. Value 3 never occurs.
- R10: `trace_addr`, `trace_data` and the kind are the values of `cpu_addr`, `cpu_data`, `cpu_rw` and `cpu_sync` at the clock edge where `phi2` falls. The record shows on `trace_valid` from the next clock.
- R11: While `trace_valid` is high and `trace_ready` is low, the record stays stable and `phi2` does not fall.
- R12: Command codes 6 and 7 are ignored and leave the mode and `resb` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cfg_low_len | input | LOW_W | Minimum low-phase length of PHI2, minus one, in clocks |
| cmd_valid | input | 1 | Command strobe, one clock per command |
| cmd_op | input | 3 | Command code (0 hold, 1 run, 2 cycle step, 3 instruction step, 4 reset on, 5 reset off) |
| cpu_addr | input | ADDR_W | Processor address bus |
| cpu_data | input | DATA_W | Processor data bus |
| cpu_rw | input | 1 | Processor read/write, high for read |
| cpu_sync | input | 1 | Processor opcode-fetch marker |
| phi2 | output | 1 | Generated processor phase-2 clock |
| resb | output | 1 | Processor reset, active low |
| trace_valid | output | 1 | Trace record present |
| trace_ready | input | 1 | Consumer accepts the record |
| trace_count | output | CNT_W | Cycles since processor reset release |
| trace_kind | output | 2 | Cycle class (0 read, 1 write, 2 fetch) |
| trace_addr | output | ADDR_W | Sampled address |
| trace_data | output | DATA_W | Sampled data |

## Verification
The assertions assume that the block reset is asserted from time zero and that `cmd_op` is a known value whenever `cmd_valid` is high. The low-phase length check compares against `cfg_low_len` as it is in the cycle of the rise. The stimulus therefore changes that setting only at a falling clock edge and holds it steady while the phases are being measured. The bench processor changes its address, read/write and sync lines only shortly after `phi2` falls, as a real processor would. As a result, the bus is always settled at the end of the low phase and at the falling edge where the block samples it.

// File: rtl/busstep_pkg.sv
package busstep_pkg;

   typedef enum logic [2:0] {
      OP_HOLD     = 3'd0,
      OP_RUN      = 3'd1,
      OP_STEP_CYC = 3'd2,
      OP_STEP_INS = 3'd3,
      OP_RST_ON   = 3'd4,
      OP_RST_OFF  = 3'd5
   } op_e;

   typedef enum logic [1:0] {
      M_HOLD     = 2'd0,
      M_RUN      = 2'd1,
      M_STEP_CYC = 2'd2,
      M_STEP_INS = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      K_READ  = 2'd0,
      K_WRITE = 2'd1,
      K_FETCH = 2'd2
   } kind_e;

   // Write wins over sync; fetch needs sync with a read.
   function automatic kind_e classify(input logic rw, input logic sync);
      if (!rw)
         return K_WRITE;
      else if (sync)
         return K_FETCH;
      else
         return K_READ;
   endfunction

endpackage

// File: rtl/busstep_phase.sv
module busstep_phase #(
   parameter int LOW_W    = 8,
   parameter int HIGH_LEN = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LOW_W-1:0] low_len,
   input  logic             go,
   input  logic             fall_ok,
   output logic             phi2,
   output logic             at_gate,
   output logic             rise_evt,
   output logic             fall_evt
);
   localparam int            HW    = (HIGH_LEN > 1) ? $clog2(HIGH_LEN) : 1;
   localparam logic [HW-1:0] HLAST = HW'(HIGH_LEN - 1);

   logic [LOW_W-1:0] low_cnt;
   logic [HW-1:0]    high_cnt;

   assign at_gate  = !phi2 && (low_cnt >= low_len);
   assign rise_evt = at_gate && go;
   assign fall_evt = phi2 && (high_cnt == HLAST) && fall_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phi2     <= 1'b0;
         low_cnt  <= '0;
         high_cnt <= '0;
      end else if (rise_evt) begin
         phi2     <= 1'b1;
         high_cnt <= '0;
         low_cnt  <= '0;
      end else if (fall_evt) begin
         phi2    <= 1'b0;
         low_cnt <= '0;
      end else if (!phi2) begin
         if (low_cnt < low_len)
            low_cnt <= low_cnt + 1'b1;
      end else begin
         if (high_cnt != HLAST)
            high_cnt <= high_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/busstep_seq.sv
module busstep_seq
   import busstep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_op,
   input  logic       at_gate,
   input  logic       rise_evt,
   input  logic       cpu_sync,
   output logic       go,
   output logic       resb
);
   mode_e mode;
   logic  started;
   logic  sets_mode;
   logic  sync_stop;

   assign sets_mode = cmd_valid && (cmd_op <= 3'd3);
   assign sync_stop = at_gate && (mode == M_STEP_INS) && started && cpu_sync;
   assign go = (mode == M_RUN) || (mode == M_STEP_CYC) ||
               ((mode == M_STEP_INS) && !(started && cpu_sync));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= M_HOLD;
         started <= 1'b0;
      end else if (sets_mode) begin
         mode    <= mode_e'(cmd_op[1:0]);
         started <= 1'b0;
      end else begin
         if (rise_evt && (mode == M_STEP_INS))
            started <= 1'b1;
         if (rise_evt && (mode == M_STEP_CYC))
            mode <= M_HOLD;
         else if (sync_stop) begin
            mode    <= M_HOLD;
            started <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         resb <= 1'b0;
      else if (cmd_valid && (op_e'(cmd_op) == OP_RST_ON))
         resb <= 1'b0;
      else if (cmd_valid && (op_e'(cmd_op) == OP_RST_OFF))
         resb <= 1'b1;
   end

endmodule

// File: rtl/busstep_count.sv
module busstep_count #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resb,
   input  logic             tick,
   output logic [CNT_W-1:0] next_val
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] incr;

   generate
      if (SATURATE) begin : g_sat
         assign incr = (cnt == {CNT_W{1'b1}}) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign incr = cnt + 1'b1;
      end
   endgenerate

   assign next_val = resb ? incr : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!resb)
         cnt <= '0;
      else if (tick)
         cnt <= incr;
   end

endmodule

// File: rtl/busstep_trace.sv
module busstep_trace #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [CNT_W-1:0]  in_count,
   input  logic [1:0]        in_kind,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic              ready,
   output logic              slot_free,
   output logic              valid,
   output logic [CNT_W-1:0]  out_count,
   output logic [1:0]        out_kind,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);
   assign slot_free = !valid || ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid     <= 1'b0;
         out_count <= '0;
         out_kind  <= '0;
         out_addr  <= '0;
         out_data  <= '0;
      end else if (capture) begin
         valid     <= 1'b1;
         out_count <= in_count;
         out_kind  <= in_kind;
         out_addr  <= in_addr;
         out_data  <= in_data;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/busstep_monitor.sv
module busstep_monitor
   import busstep_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 32,
   parameter int LOW_W    = 8,
   parameter int HIGH_LEN = 2,
   parameter bit SATURATE = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LOW_W-1:0]  cfg_low_len,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_rw,
   input  logic              cpu_sync,
   output logic              phi2,
   output logic              resb,
   output logic              trace_valid,
   input  logic              trace_ready,
   output logic [CNT_W-1:0]  trace_count,
   output logic [1:0]        trace_kind,
   output logic [ADDR_W-1:0] trace_addr,
   output logic [DATA_W-1:0] trace_data
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("busstep_monitor: bus widths must be positive");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("busstep_monitor: CNT_W must be at least 2");
      end
      if (LOW_W < 1) begin : g_bad_low
         $error("busstep_monitor: LOW_W must be at least 1");
      end
      if (HIGH_LEN < 1) begin : g_bad_high
         $error("busstep_monitor: HIGH_LEN must be at least 1");
      end
   endgenerate

   logic             go;
   logic             at_gate;
   logic             rise_evt;
   logic             fall_evt;
   logic             slot_free;
   logic [CNT_W-1:0] cyc_next;
   kind_e            cyc_kind;

   assign cyc_kind = classify(cpu_rw, cpu_sync);

   busstep_phase #(.LOW_W(LOW_W), .HIGH_LEN(HIGH_LEN)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .low_len  (cfg_low_len),
      .go       (go),
      .fall_ok  (slot_free),
      .phi2     (phi2),
      .at_gate  (at_gate),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   busstep_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .at_gate   (at_gate),
      .rise_evt  (rise_evt),
      .cpu_sync  (cpu_sync),
      .go        (go),
      .resb      (resb)
   );

   busstep_count #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .resb     (resb),
      .tick     (fall_evt),
      .next_val (cyc_next)
   );

   busstep_trace #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_trace (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (fall_evt),
      .in_count  (cyc_next),
      .in_kind   (cyc_kind),
      .in_addr   (cpu_addr),
      .in_data   (cpu_data),
      .ready     (trace_ready),
      .slot_free (slot_free),
      .valid     (trace_valid),
      .out_count (trace_count),
      .out_kind  (trace_kind),
      .out_addr  (trace_addr),
      .out_data  (trace_data)
   );

endmodule

// File: rtl/busstep_monitor_chk.sv
module busstep_monitor_chk #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 32,
   parameter int LOW_W    = 8,
   parameter int HIGH_LEN = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic [LOW_W-1:0]  cfg_low_len,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic              phi2,
   input logic              resb,
   input logic              trace_valid,
   input logic              trace_ready,
   input logic [CNT_W-1:0]  trace_count,
   input logic [1:0]        trace_kind,
   input logic [ADDR_W-1:0] trace_addr,
   input logic [DATA_W-1:0] trace_data
);
   logic [31:0] hi_run;
   logic [31:0] lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else begin
         hi_run <= phi2 ? ((hi_run == 32'hFFFF_FFFF) ? hi_run : hi_run + 1) : '0;
         lo_run <= !phi2 ? ((lo_run == 32'hFFFF_FFFF) ? lo_run : lo_run + 1) : '0;
      end
   end

   always @(posedge clk) begin
      if (!rst_n)
         a_r1_reset_state: assert (!phi2 && !resb && !trace_valid);
   end

   a_r2_min_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phi2) |-> (hi_run >= 32'(HIGH_LEN)));

   a_r2_min_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phi2) |-> (lo_run >= 32'(cfg_low_len) + 32'd1));

   a_r6_reset_on: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd4) |=> !resb);

   a_r6_reset_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd5) |=> resb);

   a_r7_zero_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(phi2) && !$past(resb)) |-> (trace_valid && trace_count == '0));

   a_r9_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
      trace_valid |-> (trace_kind != 2'b11));

   a_r11_no_fall_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (phi2 && trace_valid && !trace_ready) |=> phi2);

   a_r11_record_held: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_valid && !trace_ready) |=> (trace_valid && $stable(trace_count) &&
         $stable(trace_kind) && $stable(trace_addr) && $stable(trace_data)));

endmodule

bind busstep_monitor busstep_monitor_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LOW_W(LOW_W), .HIGH_LEN(HIGH_LEN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_low_len (cfg_low_len),
   .cmd_valid   (cmd_valid),
   .cmd_op      (cmd_op),
   .phi2        (phi2),
   .resb        (resb),
   .trace_valid (trace_valid),
   .trace_ready (trace_ready),
   .trace_count (trace_count),
   .trace_kind  (trace_kind),
   .trace_addr  (trace_addr),
   .trace_data  (trace_data)
);

// File: tb/tb_busstep_monitor.sv
module tb_busstep_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 16;
   localparam int DATA_W     = 8;
   localparam int CNT_W      = 4;
   localparam int LOW_W      = 4;
   localparam int HIGH_LEN   = 2;
   localparam int CMAX       = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [LOW_W-1:0]  cfg_low_len = 4'd3;
   logic              cmd_valid = 1'b0;
   logic [2:0]        cmd_op = 3'd0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_data = '0;
   logic              cpu_rw = 1'b1;
   logic              cpu_sync = 1'b0;
   logic              phi2;
   logic              resb;
   logic              trace_valid;
   logic              trace_ready = 1'b1;
   logic [CNT_W-1:0]  trace_count;
   logic [1:0]        trace_kind;
   logic [ADDR_W-1:0] trace_addr;
   logic [DATA_W-1:0] trace_data;

   int n_cmp = 0;
   int n_mis = 0;

   busstep_monitor #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .LOW_W(LOW_W), .HIGH_LEN(HIGH_LEN), .SATURATE(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cfg_low_len(cfg_low_len),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_rw(cpu_rw), .cpu_sync(cpu_sync),
      .phi2(phi2), .resb(resb),
      .trace_valid(trace_valid), .trace_ready(trace_ready),
      .trace_count(trace_count), .trace_kind(trace_kind),
      .trace_addr(trace_addr), .trace_data(trace_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_mis++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Fake processor: a new cycle starts shortly after each PHI2 fall.
   int ci = 0;
   int ins_left = 0;
   int ins_no = 0;
   task automatic cpu_advance();
      if (ins_left == 0) begin
         cpu_sync = 1'b1;
         cpu_rw   = 1'b1;
         ins_left = 1 + (ins_no % 3);
         ins_no++;
      end else begin
         cpu_sync = 1'b0;
         cpu_rw   = ((ci % 3) != 1);
         ins_left--;
      end
      cpu_addr = ADDR_W'(16'h0200 + ci * 5);
      cpu_data = DATA_W'(ci * 37 + 11);
      ci++;
   endtask

   initial begin
      cpu_advance();
      forever begin
         @(negedge phi2);
         #1;
         cpu_advance();
      end
   end

   // Behavioural reference, stepped on each rising clock edge.
   bit          m_phi = 0, m_resb = 0, m_val = 0, m_start = 0;
   int          m_lo = 0, m_hi = 0, m_mode = 0, m_cnt = 0;
   int          r_cnt = 0, r_kind = 0, r_addr = 0, r_data = 0;
   int          n_rec = 0, last_cnt = 0;
   int          kq[$];

   always @(posedge clk) begin
      if (trace_valid && trace_ready) begin
         n_rec++;
         kq.push_back(int'(trace_kind));
         last_cnt = int'(trace_count);
      end
      if (!rst_n) begin
         m_phi = 0; m_resb = 0; m_val = 0; m_start = 0;
         m_lo = 0; m_hi = 0; m_mode = 0; m_cnt = 0;
      end else begin
         bit gate, go, rise, fall;
         int om, nc;
         bit os;
         om = m_mode;
         os = m_start;
         gate = !m_phi && (m_lo >= int'(cfg_low_len));
         go   = (om == 1) || (om == 2) || (om == 3 && !(os && cpu_sync));
         rise = gate && go;
         fall = m_phi && (m_hi >= HIGH_LEN - 1) && (!m_val || trace_ready);
         nc = 0;
         if (fall) begin
            nc = m_resb ? ((m_cnt == CMAX) ? m_cnt : m_cnt + 1) : 0;
            r_cnt  = nc;
            r_kind = !cpu_rw ? 1 : (cpu_sync ? 2 : 0);
            r_addr = int'(cpu_addr);
            r_data = int'(cpu_data);
            m_val  = 1;
         end else if (trace_ready) begin
            m_val = 0;
         end
         if (!m_resb) m_cnt = 0;
         else if (fall) m_cnt = nc;
         if (cmd_valid && cmd_op <= 3'd3) begin
            m_mode  = int'(cmd_op);
            m_start = 0;
         end else begin
            if (rise && om == 3) m_start = 1;
            if (rise && om == 2) m_mode = 0;
            else if (gate && om == 3 && os && cpu_sync) begin
               m_mode = 0;
               m_start = 0;
            end
         end
         if (cmd_valid && cmd_op == 3'd4) m_resb = 0;
         else if (cmd_valid && cmd_op == 3'd5) m_resb = 1;
         if (rise) begin
            m_phi = 1; m_hi = 0; m_lo = 0;
         end else if (fall) begin
            m_phi = 0; m_lo = 0;
         end else if (!m_phi) begin
            if (m_lo < int'(cfg_low_len)) m_lo++;
         end else begin
            if (m_hi < HIGH_LEN - 1) m_hi++;
         end
      end
   end

   // Per-clock comparison against the reference.
   always @(negedge clk) begin
      check(phi2 == m_phi, "R3 phi2", phi2, m_phi);
      check(resb == m_resb, "R6 resb", resb, m_resb);
      check(trace_valid == m_val, "R11 trace_valid", trace_valid, m_val);
      if (trace_valid && m_val) begin
         check(int'(trace_count) == r_cnt, "R7 count", trace_count, r_cnt);
         check(int'(trace_kind) == r_kind, "R9 kind", trace_kind, r_kind);
         check(int'(trace_addr) == r_addr, "R10 addr", trace_addr, r_addr);
         check(int'(trace_data) == r_data, "R10 data", trace_data, r_data);
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [2:0] op);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic measure(output int hi_n, output int lo_n);
      @(negedge clk);
      while (phi2) @(negedge clk);
      while (!phi2) @(negedge clk);
      hi_n = 0;
      while (phi2) begin hi_n++; @(negedge clk); end
      lo_n = 0;
      while (!phi2) begin lo_n++; @(negedge clk); end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_mis++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int n0, hn, ln, fetches;
      logic [ADDR_W-1:0] a0;
      logic [CNT_W-1:0]  c0;
      wait_clk(3);
      check(phi2 == 1'b0, "R1 phi2 in reset", phi2, 0);
      check(resb == 1'b0, "R1 resb in reset", resb, 0);
      check(trace_valid == 1'b0, "R1 valid in reset", trace_valid, 0);
      rst_n = 1'b1;
      n0 = n_rec;
      wait_clk(15);
      check(phi2 == 1'b0 && n_rec == n0, "R1 holds after reset", phi2, 0);

      // R12: unknown code in hold changes nothing
      n0 = n_rec;
      send(3'd7);
      wait_clk(15);
      check(n_rec == n0, "R12 code 7 ignored in hold", n_rec - n0, 0);
      check(resb == 1'b0, "R12 resb unchanged", resb, 0);

      // R4 / R7: step while processor held in reset reports count 0
      n0 = n_rec;
      send(3'd2);
      wait_clk(30);
      check(n_rec - n0 == 1, "R4 one cycle per step", n_rec - n0, 1);
      check(last_cnt == 0, "R7 count zero in reset", last_cnt, 0);
      check(phi2 == 1'b0, "R4 stops low", phi2, 0);

      send(3'd5);
      check(resb == 1'b1, "R6 release", resb, 1);

      n0 = n_rec;
      send(3'd2);
      wait_clk(30);
      check(n_rec - n0 == 1, "R4 single step after release", n_rec - n0, 1);
      check(last_cnt == 1, "R7 first count is 1", last_cnt, 1);

      // R5: instruction step
      n0 = n_rec;
      send(3'd3);
      wait_clk(120);
      check(n_rec - n0 >= 1, "R5 at least one cycle", n_rec - n0, 1);
      fetches = 0;
      for (int i = n0 + 1; i < n_rec; i++)
         if (kq[i] == 2) fetches++;
      check(fetches == 0, "R5 no fetch after first", fetches, 0);
      check(cpu_sync == 1'b1 && phi2 == 1'b0, "R5 parked before fetch", cpu_sync, 1);
      n0 = n_rec;
      send(3'd3);
      wait_clk(120);
      check(n_rec - n0 >= 1 && kq[n0] == 2, "R5 step starts with fetch", kq[n0], 2);

      // R2 / R3: run and measure phases
      cfg_low_len = 4'd2;
      send(3'd1);
      measure(hn, ln);
      check(hn == HIGH_LEN, "R2 high length", hn, HIGH_LEN);
      check(ln == 3, "R2 low length cfg=2", ln, 3);
      @(negedge clk);
      cfg_low_len = 4'd5;
      measure(hn, ln);
      measure(hn, ln);
      check(ln == 6, "R2 low length cfg=5", ln, 6);

      // R12 in run: code 6 ignored, clock keeps running
      send(3'd6);
      n0 = n_rec;
      wait_clk(60);
      check(n_rec - n0 >= 5, "R12 code 6 ignored in run", n_rec - n0, 5);

      // R8: saturation
      wait_clk(200);
      check(last_cnt == CMAX, "R8 saturates", last_cnt, CMAX);

      // R11: back-pressure
      trace_ready = 1'b0;
      wait_clk(40);
      a0 = trace_addr;
      c0 = trace_count;
      wait_clk(20);
      check(phi2 == 1'b1, "R11 phi2 held high", phi2, 1);
      check(trace_valid && trace_addr == a0 && trace_count == c0, "R11 record held",
            trace_addr, a0);
      trace_ready = 1'b1;
      wait_clk(5);

      // R3: hold
      send(3'd0);
      wait_clk(20);
      n0 = n_rec;
      wait_clk(30);
      check(n_rec == n0 && phi2 == 1'b0, "R3 hold stops clock", n_rec - n0, 0);

      // R6 / R7: reassert then release processor reset
      send(3'd4);
      check(resb == 1'b0, "R6 reset on", resb, 0);
      send(3'd2);
      wait_clk(30);
      check(last_cnt == 0, "R7 zero while reset", last_cnt, 0);
      send(3'd5);
      send(3'd2);
      wait_clk(30);
      check(last_cnt == 1, "R7 restarts at 1", last_cnt, 1);

      summary();
      $finish;
   end

endmodule